// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer register value into an IEEE 754 binary64 number in one clocked stage. A two-bit source-type select tells it whether to read the operand as signed or unsigned, and as a 32-bit or a 64-bit quantity. A precision select makes it round either to binary64 or to binary32. A binary32 result is re-expressed in binary64 form before it leaves the block. Rounding follows a two-bit rounding-mode input.

Next to the result, the block reports three things about the rounding step. The first is a five-bit class code for the value. The second is a flag that says the magnitude was rounded up. The third is a flag that says the result is not exact. When the result is inexact, the block raises a request to set the sticky inexact status bit and the summary exception bit. A status write-enable tells the surrounding pipeline whether any of these status outputs should be written. It is low only for the one case that can never round: a 32-bit source converted at double precision.

Top module: `i2f_convert`

## Requirements
- R1: The source type `in_type` is decoded as follows: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. The 32-bit types read only `in_value[31:0]`, and bits 63:32 have no effect on any output.
- R2: An operand accepted with `in_valid` high at a rising edge appears at the outputs after that edge, with `out_valid` high. `out_valid` is low in every cycle that follows an edge with no accepted operand.
- R3: When a 32-bit source type is converted at double precision (`in_single`=0, `in_type[1]`=0), the result is exact. In that case `out_flags_we`, `out_fr`, `out_fi`, `out_ix_set` and `out_class` are all zero.
- R4: In every other case the value is rounded according to `in_rmode`: 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward +infinity and 11 rounds toward -infinity. `out_flags_we` is 1.
- R5: `out_fr` is 1 exactly when rounding increased the magnitude. This includes a carry out of the significand, which raises the exponent by one.
- R6: `out_fi` is 1 exactly when the rounded result differs from the integer. `out_ix_set` equals `out_fi` and requests the setting of both the sticky inexact bit and the summary exception bit.
- R7: With `in_single`=1 the value is rounded to binary32 (24 significant bits) and given in binary64 form. `out_result[28:0]` is therefore always zero.
- R8: The class code is 00100 for a positive normal, 01000 for a negative normal and 00010 for +zero. An integer zero gives an all-zero result and class 00010.
- R9: After a synchronous reset, `out_valid`, `out_result` and every flag output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_value | input | 64 | Integer register value |
| in_type | input | 2 | Source type select |
| in_single | input | 1 | 1: round to binary32, 0: round to binary64 |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | binary64 result |
| out_class | output | 5 | Result class code |
| out_flags_we | output | 1 | Status outputs carry an update |
| out_fr | output | 1 | Magnitude was rounded up |
| out_fi | output | 1 | Result is inexact |
| out_ix_set | output | 1 | Request to set the inexact and summary exception bits |

## Verification
Every result is registered once, so the result is due one edge after the edge that accepted the operand. The driver applies each operand on a falling edge. At the same moment it queues the expected values, which come from an exact divide-and-remainder reference model. The monitor samples one time unit after each rising edge. At that point it pops one queued item for every cycle in which `out_valid` is high, and it flags any `out_valid` that has no operand behind it. Operands also arrive back to back and with idle gaps, so the one-cycle pairing is checked in both situations.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  typedef enum logic [1:0] {
    SRC_S32 = 2'd0,
    SRC_U32 = 2'd1,
    SRC_S64 = 2'd2,
    SRC_U64 = 2'd3
  } src_type_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  localparam logic [4:0] CLS_POS_NORMAL = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORMAL = 5'b01000;
  localparam logic [4:0] CLS_POS_ZERO   = 5'b00010;
  localparam logic [4:0] CLS_NONE       = 5'b00000;
endpackage

// File: rtl/i2f_unpack.sv
module i2f_unpack #(
  parameter int XLEN = 64,
  parameter int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      src_type,
  output logic            sign,
  output logic [XLEN-1:0] mag
);
  import i2f_pkg::*;

  logic [XLEN-1:0] ext;

  always_comb begin
    unique case (src_type_e'(src_type))
      SRC_S32: begin
        ext  = {{(XLEN-HALF){raw[HALF-1]}}, raw[HALF-1:0]};
        sign = raw[HALF-1];
      end
      SRC_U32: begin
        ext  = {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]};
        sign = 1'b0;
      end
      SRC_S64: begin
        ext  = raw;
        sign = raw[XLEN-1];
      end
      default: begin
        ext  = raw;
        sign = 1'b0;
      end
    endcase
    mag = sign ? (~ext + {{(XLEN-1){1'b0}}, 1'b1}) : ext;
  end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  mag,
  output logic [IDX_W-1:0] msb_idx,
  output logic [XLEN-2:0]  tail,
  output logic             is_zero
);
  logic [XLEN-1:0] shifted;

  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (mag[i]) msb_idx = IDX_W'(i);
    end
    shifted = mag << (IDX_W'(XLEN-1) - msb_idx);
    tail    = shifted[XLEN-2:0];
    is_zero = ~shifted[XLEN-1];
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round #(
  parameter int XLEN   = 64,
  parameter int MANT_W = 53,
  parameter int TW     = XLEN - 1,
  parameter int FW     = MANT_W - 1
) (
  input  logic [TW-1:0] tail,
  input  logic          sign,
  input  logic [1:0]    rmode,
  output logic [FW-1:0] frac,
  output logic          carry,
  output logic          inc,
  output logic          inexact
);
  import i2f_pkg::*;

  logic [FW-1:0] kept;
  logic          guard;
  logic          sticky;
  logic [FW:0]   sum;

  always_comb begin
    kept    = tail[TW-1 -: FW];
    guard   = tail[TW-1-FW];
    sticky  = |tail[TW-2-FW:0];
    inexact = guard | sticky;
    unique case (rmode_e'(rmode))
      RM_NEAR_EVEN: inc = guard & (sticky | kept[0]);
      RM_TO_ZERO:   inc = 1'b0;
      RM_TO_POS:    inc = inexact & ~sign;
      default:      inc = inexact & sign;
    endcase
    sum   = {1'b0, kept} + {{FW{1'b0}}, inc};
    carry = sum[FW];
    frac  = sum[FW-1:0];
  end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert #(
  parameter int XLEN      = 64,
  parameter int EXP_W     = 11,
  parameter int FRAC_W    = 52,
  parameter int SP_FRAC_W = 23
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_value,
  input  logic [1:0]      in_type,
  input  logic            in_single,
  input  logic [1:0]      in_rmode,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic [4:0]      out_class,
  output logic            out_flags_we,
  output logic            out_fr,
  output logic            out_fi,
  output logic            out_ix_set
);
  import i2f_pkg::*;

  localparam int IDX_W = $clog2(XLEN);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int PAD_W = FRAC_W - SP_FRAC_W;
  localparam int NPREC = 2;

  logic             sign;
  logic [XLEN-1:0]  mag;
  logic [IDX_W-1:0] msb_idx;
  logic [XLEN-2:0]  tail;
  logic             is_zero;

  i2f_unpack #(.XLEN(XLEN)) unpack_i (
    .raw(in_value), .src_type(in_type), .sign(sign), .mag(mag)
  );

  i2f_normalize #(.XLEN(XLEN)) norm_i (
    .mag(mag), .msb_idx(msb_idx), .tail(tail), .is_zero(is_zero)
  );

  // index 0: binary64 rounding, index 1: binary32 rounding
  logic [FRAC_W-1:0] frac_p [NPREC];
  logic [NPREC-1:0]  carry_p, inc_p, inexact_p;

  generate
    for (genvar p = 0; p < NPREC; p++) begin : g_prec
      localparam int FW = (p == 0) ? FRAC_W : SP_FRAC_W;
      logic [FW-1:0] frac_raw;
      i2f_round #(.XLEN(XLEN), .MANT_W(FW + 1)) round_i (
        .tail(tail), .sign(sign), .rmode(in_rmode),
        .frac(frac_raw), .carry(carry_p[p]), .inc(inc_p[p]),
        .inexact(inexact_p[p])
      );
      if (p == 0) begin : g_dbl
        assign frac_p[p] = frac_raw;
      end else begin : g_sgl
        assign frac_p[p] = {frac_raw, {PAD_W{1'b0}}};
      end
    end
  endgenerate

  logic             sel;
  logic             exact_path;
  logic [EXP_W-1:0] bexp;
  logic [XLEN-1:0]  result_c;
  logic [4:0]       class_c;
  logic             fr_c, fi_c;

  always_comb begin
    sel        = in_single;
    exact_path = ~in_single & ~in_type[1];
    bexp       = EXP_W'(msb_idx) + EXP_W'(BIAS) + {{(EXP_W-1){1'b0}}, carry_p[sel]};
    if (is_zero) begin
      result_c = '0;
      class_c  = CLS_POS_ZERO;
      fr_c     = 1'b0;
      fi_c     = 1'b0;
    end else begin
      result_c = {sign, bexp, frac_p[sel]};
      class_c  = sign ? CLS_NEG_NORMAL : CLS_POS_NORMAL;
      fr_c     = inc_p[sel];
      fi_c     = inexact_p[sel];
    end
    if (exact_path) begin
      class_c = CLS_NONE;
      fr_c    = 1'b0;
      fi_c    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_class    <= CLS_NONE;
      out_flags_we <= 1'b0;
      out_fr       <= 1'b0;
      out_fi       <= 1'b0;
      out_ix_set   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= result_c;
        out_class    <= class_c;
        out_flags_we <= ~exact_path;
        out_fr       <= fr_c;
        out_fi       <= fi_c;
        out_ix_set   <= fi_c;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_exact_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_single && !in_type[1]) |=>
      (!out_flags_we && !out_fr && !out_fi && !out_ix_set && out_class == 5'b0));

  assert_inc_implies_inexact_R5: assert property (@(posedge clk) disable iff (rst)
    out_fr |-> out_fi);

  assert_sticky_request_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ix_set == out_fi));

  assert_single_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_single) |=> (out_result[PAD_W-1:0] == '0));

  assert_class_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags_we) |-> ($countones(out_class[3:1]) == 1));
endmodule

// File: tb/i2f_convert_tb.sv
`timescale 1ns/1ps
module i2f_convert_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_value;
  logic [1:0]  in_type;
  logic        in_single;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_class;
  logic        out_flags_we, out_fr, out_fi, out_ix_set;

  always #5 clk = ~clk;

  i2f_convert dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .in_type(in_type), .in_single(in_single), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
    .out_flags_we(out_flags_we), .out_fr(out_fr), .out_fi(out_fi),
    .out_ix_set(out_ix_set)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  cls;
    logic        we, fr, fi;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  // Exact reference: quotient/remainder against the halfway point.
  function automatic exp_t model(input logic [63:0] v, input logic [1:0] t,
                                 input logic sgl, input logic [1:0] rm,
                                 input string tag);
    exp_t        e;
    logic        s;
    logic [63:0] m, qv, r, half;
    int          top, p, sh;
    logic        up, inx;
    e.tag = tag;
    case (t)
      2'd0: begin s = v[31]; m = s ? 64'(-$signed({{32{v[31]}}, v[31:0]})) : {32'b0, v[31:0]}; end
      2'd1: begin s = 1'b0; m = {32'b0, v[31:0]}; end
      2'd2: begin s = v[63]; m = s ? (64'd0 - v) : v; end
      default: begin s = 1'b0; m = v; end
    endcase
    if (m == 0) begin
      e.res = 64'd0; e.cls = 5'b00010; e.fr = 0; e.fi = 0;
    end else begin
      top = 0;
      for (int i = 0; i < 64; i++) if (m >= (64'd1 << i)) top = i;
      p = sgl ? 24 : 53;
      up = 0; inx = 0;
      if (top >= p) begin
        sh   = top - p + 1;
        qv   = m >> sh;
        r    = m - (qv << sh);
        half = 64'd1 << (sh - 1);
        inx  = (r != 0);
        case (rm)
          2'd0: up = (r > half) || (r == half && qv[0]);
          2'd1: up = 0;
          2'd2: up = inx && !s;
          default: up = inx && s;
        endcase
        qv = qv + 64'(up);
        if (qv == (64'd1 << p)) begin qv = qv >> 1; top = top + 1; end
      end else begin
        qv = m << (p - 1 - top);
      end
      e.res[63]    = s;
      e.res[62:52] = 11'(top + 1023);
      e.res[51:0]  = sgl ? {qv[22:0], 29'b0} : qv[51:0];
      e.cls = s ? 5'b01000 : 5'b00100;
      e.fr = up; e.fi = inx;
    end
    e.we = sgl || t[1];
    if (!e.we) begin e.cls = 5'b0; e.fr = 0; e.fi = 0; end
    return e;
  endfunction

  task automatic drive(input logic [63:0] v, input logic [1:0] t,
                       input logic sgl, input logic [1:0] rm, input string tag);
    @(negedge clk);
    in_valid = 1; in_value = v; in_type = t; in_single = sgl; in_rmode = rm;
    q.push_back(model(v, t, sgl, rm, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_value = 64'hDEAD_BEEF_DEAD_BEEF;
  endtask

  // Monitor: results are due one edge after acceptance.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2: out_valid with nothing pending, actual=1 expected=0");
        end else begin
          e = q.pop_front();
          if (out_result !== e.res || out_class !== e.cls || out_flags_we !== e.we ||
              out_fr !== e.fr || out_fi !== e.fi || out_ix_set !== e.fi) begin
            errors++;
            $display("FAIL %s: actual res=%h cls=%b we=%b fr=%b fi=%b ix=%b expected res=%h cls=%b we=%b fr=%b fi=%b ix=%b",
                     e.tag, out_result, out_class, out_flags_we, out_fr, out_fi, out_ix_set,
                     e.res, e.cls, e.we, e.fr, e.fi, e.fi);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_value = '0; in_type = 0; in_single = 0; in_rmode = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || out_result !== 0 || out_fr !== 0 || out_fi !== 0 ||
        out_ix_set !== 0 || out_flags_we !== 0 || out_class !== 0) begin
      errors++;
      $display("FAIL R9: actual valid=%b res=%h expected valid=0 res=0", out_valid, out_result);
    end
    @(negedge clk); rst = 0;

    drive(64'h0020_0000_0000_0001, 2'd3, 0, 2'd0, "R4 2^53+1 nearest");
    drive(64'h0020_0000_0000_0003, 2'd3, 0, 2'd0, "R5 2^53+3 tie up");
    drive(64'h0020_0000_0000_0001, 2'd3, 0, 2'd2, "R4 toward +inf");
    drive(64'h0020_0000_0000_0001, 2'd3, 0, 2'd3, "R4 toward -inf");
    drive(64'h0020_0000_0000_0001, 2'd3, 0, 2'd1, "R4 toward zero");
    drive(64'd0 - 64'h0020_0000_0000_0001, 2'd2, 0, 2'd3, "R5 negative toward -inf");
    drive(64'd0 - 64'h0020_0000_0000_0001, 2'd2, 0, 2'd2, "R4 negative toward +inf");
    drive(64'h0000_0000_0100_0001, 2'd0, 1, 2'd0, "R7 2^24+1 single");
    drive(64'h0000_0000_0100_0003, 2'd1, 1, 2'd2, "R7 single toward +inf");
    drive(64'h0000_0000_0100_0001, 2'd0, 0, 2'd2, "R3 2^24+1 double exact");
    drive(64'h1234_5678_8000_0000, 2'd0, 0, 2'd0, "R1 s32 min, upper ignored");
    drive(64'hFFFF_FFFF_0000_0005, 2'd1, 1, 2'd0, "R1 u32 upper ignored");
    drive(64'h8000_0000_0000_0000, 2'd2, 0, 2'd0, "R1 s64 min");
    drive(64'h8000_0000_0000_0000, 2'd2, 1, 2'd1, "R7 s64 min single");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd0, "R5 all-ones carry");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd1, "R6 all-ones truncate");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd0, "R8 s64 minus one");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1, 2'd0, "R5 u32 all-ones single carry");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 0, 2'd0, "R3 u32 all-ones double");
    drive(64'h0, 2'd3, 0, 2'd0, "R8 zero u64");
    drive(64'hABCD_0000_0000_0000, 2'd0, 1, 2'd3, "R8 zero s32 single");
    idle(); idle();
    drive(64'h7, 2'd2, 1, 2'd0, "R2 after gap");
    idle();

    for (int n = 0; n < 400; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 8 == 0) idle();
      drive(v, 2'($urandom), 1'($urandom), 2'($urandom), "R4 random");
    end
    idle(); idle(); idle();

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule